// File: doc/BRIEF.md
# Byte Data Memory Space with Pointer Addressing

This block is the data memory space of a small 8-bit controller. A single 8-bit address space holds a small read/write RAM, a range of unimplemented RAM that reads back as all ones, and three pointer registers (B, X and the stack pointer). The pointer registers sit at fixed locations inside that same space. Peripheral registers elsewhere in the map are outside this block and are modelled as a hole.

Each request carries an addressing mode. The operand address comes either from an 8-bit direct field, or from the B or X pointer. In the pointer modes the chosen pointer can step up or down by one after the access. A separate short-immediate port loads B with a 4-bit value. The datapath sees a combinational read port and a write that takes effect at the clock edge. Every request completes in one cycle.

Top module: `dmem_space`

## Requirements
- R1: Addresses 0x00 to 0x2F are 48 bytes of RAM. A write with `req_valid` and `req_we` high is stored at the rising edge. A read returns the stored byte combinationally in the same cycle.
- R2: A read of any address from 0x30 to 0x7F returns 0xFF. Writes there change nothing.
- R3: A read of 0x80 to 0xFB or of 0xFF returns 0x00. Writes there change nothing.
- R4: X is at 0xFC, SP at 0xFD and B at 0xFE. Each can be read, and each can be written like RAM.
- R5: `req_mode` 0 (direct) uses `req_addr` as the address. `req_mode` 1 (indirect) uses B when `req_ptr_sel`=0 and X when `req_ptr_sel`=1. Neither mode changes a pointer.
- R6: `req_mode` 2 (indirect, post-increment) addresses through the old value of the selected pointer. After the edge that pointer holds the old value plus one, modulo 256 (0xFF wraps to 0x00).
- R7: `req_mode` 3 (indirect, post-decrement) addresses through the old value of the selected pointer. After the edge that pointer holds the old value minus one, modulo 256 (0x00 wraps to 0xFF).
- R8: When `ldb_valid` is high, B is loaded at the edge with `ldb_imm` zero-extended to 8 bits. This load wins over any step of B and over any write to 0xFE in the same cycle.
- R9: A data write that lands on the location of the pointer being stepped in the same cycle is overridden by the step.
- R10: Synchronous active-high reset clears B, X and SP to 0x00.
- R11: While `req_valid` is low, no RAM byte changes, and no pointer changes apart from an `ldb_valid` load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 indirect post-inc, 3 indirect post-dec |
| req_ptr_sel | input | 1 | Pointer for the indirect modes: 0 = B, 1 = X |
| req_addr | input | 8 | Direct address field |
| req_we | input | 1 | Write enable for the request |
| req_wdata | input | 8 | Write data |
| ldb_valid | input | 1 | Load B from the short immediate |
| ldb_imm | input | 4 | Short immediate value, 0 to 15 |
| rd_data | output | 8 | Read data at the resolved address |

## Verification
A direct-mode sweep first writes an address-dependent pattern to all 256 locations and then reads each one back. This separates real RAM from the all-ones range and the zero hole. It also shows that each pointer location takes the written byte. Indirect accesses through B and through X then walk pointers across the 0x2F/0x30 boundary and through both wrap points. These accesses tell a post-step apart from a pre-step, and show which pointer moved. Collision cases test priority: a short-immediate load against a B step and against a write to 0xFE, and a stepping pointer that addresses its own location. Idle cycles with write enable high must leave RAM untouched.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT  = 2'd0,
    AM_IND     = 2'd1,
    AM_IND_INC = 2'd2,
    AM_IND_DEC = 2'd3
  } amode_e;
endpackage

// File: rtl/dmem_addr_gen.sv
module dmem_addr_gen
  import dmem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  amode_e              mode,
  input  logic                ptr_sel,
  input  logic [ADDR_W-1:0]   dir_addr,
  input  logic [ADDR_W-1:0]   ptr_b,
  input  logic [ADDR_W-1:0]   ptr_x,
  output logic [ADDR_W-1:0]   eff_addr,
  output logic                step_en,
  output logic [ADDR_W-1:0]   step_val
);
  logic [ADDR_W-1:0] base;

  always_comb begin
    base     = ptr_sel ? ptr_x : ptr_b;
    eff_addr = (mode == AM_DIRECT) ? dir_addr : base;
    step_en  = (mode == AM_IND_INC) || (mode == AM_IND_DEC);
    if (mode == AM_IND_DEC) step_val = base - ADDR_W'(1);
    else                    step_val = base + ADDR_W'(1);
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 48,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];
endmodule

// File: rtl/dmem_ptr_regs.sv
module dmem_ptr_regs #(
  parameter int ADDR_W = 8,
  parameter int IMM_W  = 4,
  parameter logic [ADDR_W-1:0] X_LOC  = 8'hFC,
  parameter logic [ADDR_W-1:0] SP_LOC = 8'hFD,
  parameter logic [ADDR_W-1:0] B_LOC  = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldb_valid,
  input  logic [IMM_W-1:0]  ldb_imm,
  input  logic              step_b,
  input  logic              step_x,
  input  logic [ADDR_W-1:0] step_val,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [ADDR_W-1:0] wr_data,
  output logic [ADDR_W-1:0] ptr_b,
  output logic [ADDR_W-1:0] ptr_x,
  output logic [ADDR_W-1:0] ptr_sp
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_b  <= '0;
      ptr_x  <= '0;
      ptr_sp <= '0;
    end else begin
      if (ldb_valid)                        ptr_b <= ADDR_W'(ldb_imm);
      else if (step_b)                      ptr_b <= step_val;
      else if (wr_en && wr_addr == B_LOC)   ptr_b <= wr_data;

      if (step_x)                           ptr_x <= step_val;
      else if (wr_en && wr_addr == X_LOC)   ptr_x <= wr_data;

      if (wr_en && wr_addr == SP_LOC)       ptr_sp <= wr_data;
    end
  end
endmodule

// File: rtl/dmem_space.sv
module dmem_space
  import dmem_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter int RAM_DEPTH = 48,
  parameter int ONES_END  = 128,
  parameter int IMM_W     = 4,
  parameter logic [ADDR_W-1:0] X_LOC  = 8'hFC,
  parameter logic [ADDR_W-1:0] SP_LOC = 8'hFD,
  parameter logic [ADDR_W-1:0] B_LOC  = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_mode,
  input  logic              req_ptr_sel,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              ldb_valid,
  input  logic [IMM_W-1:0]  ldb_imm,
  output logic [DATA_W-1:0] rd_data
);
  localparam int IDX_W = $clog2(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] RAM_LAST  = ADDR_W'(RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] ONES_LAST = ADDR_W'(ONES_END - 1);

  amode_e            mode;
  logic [ADDR_W-1:0] ptr_b, ptr_x, ptr_sp;
  logic [ADDR_W-1:0] eff_addr, step_val;
  logic              step_en;
  logic              wr_en, in_ram;
  logic [DATA_W-1:0] ram_rdata;

  assign mode   = amode_e'(req_mode);
  assign wr_en  = req_valid && req_we;
  assign in_ram = (eff_addr <= RAM_LAST);

  dmem_addr_gen #(.ADDR_W(ADDR_W)) agen_i (
    .mode     (mode),
    .ptr_sel  (req_ptr_sel),
    .dir_addr (req_addr),
    .ptr_b    (ptr_b),
    .ptr_x    (ptr_x),
    .eff_addr (eff_addr),
    .step_en  (step_en),
    .step_val (step_val)
  );

  dmem_ram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH)) ram_i (
    .clk   (clk),
    .we    (wr_en && in_ram),
    .idx   (eff_addr[IDX_W-1:0]),
    .wdata (req_wdata),
    .rdata (ram_rdata)
  );

  dmem_ptr_regs #(
    .ADDR_W(ADDR_W), .IMM_W(IMM_W),
    .X_LOC(X_LOC), .SP_LOC(SP_LOC), .B_LOC(B_LOC)
  ) ptrs_i (
    .clk       (clk),
    .rst       (rst),
    .ldb_valid (ldb_valid),
    .ldb_imm   (ldb_imm),
    .step_b    (req_valid && step_en && !req_ptr_sel),
    .step_x    (req_valid && step_en && req_ptr_sel),
    .step_val  (step_val),
    .wr_en     (wr_en),
    .wr_addr   (eff_addr),
    .wr_data   (ADDR_W'(req_wdata)),
    .ptr_b     (ptr_b),
    .ptr_x     (ptr_x),
    .ptr_sp    (ptr_sp)
  );

  always_comb begin
    if (in_ram)                     rd_data = ram_rdata;
    else if (eff_addr <= ONES_LAST) rd_data = '1;
    else if (eff_addr == X_LOC)     rd_data = DATA_W'(ptr_x);
    else if (eff_addr == SP_LOC)    rd_data = DATA_W'(ptr_sp);
    else if (eff_addr == B_LOC)     rd_data = DATA_W'(ptr_b);
    else                            rd_data = '0;
  end
endmodule

// File: rtl/dmem_space_chk.sv
module dmem_space_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int IMM_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_mode,
  input logic              req_ptr_sel,
  input logic [ADDR_W-1:0] req_addr,
  input logic              ldb_valid,
  input logic [IMM_W-1:0]  ldb_imm,
  input logic [DATA_W-1:0] rd_data,
  input logic [ADDR_W-1:0] ptr_b,
  input logic [ADDR_W-1:0] ptr_x,
  input logic [ADDR_W-1:0] ptr_sp
);
  p_ones_read_r2: assert property (@(posedge clk) disable iff (rst)
    (req_mode == 2'd0 && req_addr >= 8'h30 && req_addr <= 8'h7F) |-> rd_data == 8'hFF);

  p_hole_read_r3: assert property (@(posedge clk) disable iff (rst)
    (req_mode == 2'd0 && req_addr >= 8'h80 && req_addr <= 8'hFB) |-> rd_data == 8'h00);

  p_post_inc_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd2 && !req_ptr_sel && !ldb_valid)
      |=> ptr_b == $past(ptr_b) + 8'd1);

  p_post_dec_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_mode == 2'd3 && req_ptr_sel) |=> ptr_x == $past(ptr_x) - 8'd1);

  p_ldb_prio_r8: assert property (@(posedge clk) disable iff (rst)
    ldb_valid |=> ptr_b == ADDR_W'($past(ldb_imm)));

  p_reset_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ptr_b == 8'h00 && ptr_x == 8'h00 && ptr_sp == 8'h00));

  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && !ldb_valid) |=> ($stable(ptr_b) && $stable(ptr_x) && $stable(ptr_sp)));
endmodule

bind dmem_space dmem_space_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_mode    (req_mode),
  .req_ptr_sel (req_ptr_sel),
  .req_addr    (req_addr),
  .ldb_valid   (ldb_valid),
  .ldb_imm     (ldb_imm),
  .rd_data     (rd_data),
  .ptr_b       (ptr_b),
  .ptr_x       (ptr_x),
  .ptr_sp      (ptr_sp)
);

// File: tb/dmem_space_tb.sv
`timescale 1ns/1ps
module dmem_space_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_mode = 2'd0;
  logic       req_ptr_sel = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic       req_we = 1'b0;
  logic [7:0] req_wdata = 8'h00;
  logic       ldb_valid = 1'b0;
  logic [3:0] ldb_imm = 4'h0;
  logic [7:0] rd_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] m_ram [48];
  logic [7:0] mb = 8'h00, mx = 8'h00, msp = 8'h00;

  always #2.5 clk = ~clk;

  dmem_space dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
    .req_ptr_sel(req_ptr_sel), .req_addr(req_addr), .req_we(req_we),
    .req_wdata(req_wdata), .ldb_valid(ldb_valid), .ldb_imm(ldb_imm),
    .rd_data(rd_data)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a < 8'h30)       return m_ram[a[5:0]];
    else if (a < 8'h80)  return 8'hFF;
    else if (a == 8'hFC) return mx;
    else if (a == 8'hFD) return msp;
    else if (a == 8'hFE) return mb;
    else                 return 8'h00;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One request cycle; rd_data is checked mid-cycle when do_chk is set.
  task automatic access(input logic v, input logic [1:0] md, input logic sel,
                        input logic [7:0] a, input logic we, input logic [7:0] wd,
                        input logic lv, input logic [3:0] li,
                        input bit do_chk, input string req);
    logic [7:0] eff, ob, ox, step;
    @(negedge clk);
    req_valid = v; req_mode = md; req_ptr_sel = sel; req_addr = a;
    req_we = we; req_wdata = wd; ldb_valid = lv; ldb_imm = li;
    ob = mb; ox = mx;
    eff = (md == 2'd0) ? a : (sel ? ox : ob);
    #1;
    if (do_chk) check(req, rd_data, exp_read(eff));
    if (v && we) begin
      if (eff < 8'h30) m_ram[eff[5:0]] = wd;
      if (eff == 8'hFC) mx = wd;
      if (eff == 8'hFD) msp = wd;
      if (eff == 8'hFE) mb = wd;
    end
    if (v && md[1]) begin
      step = md[0] ? ((sel ? ox : ob) - 8'd1) : ((sel ? ox : ob) + 8'd1);
      if (sel) mx = step; else mb = step;
    end
    if (lv) mb = {4'h0, li};
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_we = 1'b0; ldb_valid = 1'b0;
  endtask

  task automatic rd_dir(input logic [7:0] a, input string req);
    access(1'b1, 2'd0, 1'b0, a, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, req);
  endtask

  task automatic wr_dir(input logic [7:0] a, input logic [7:0] d);
    access(1'b1, 2'd0, 1'b0, a, 1'b1, d, 1'b0, 4'h0, 1'b0, "");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R10: pointers clear on reset
    rd_dir(8'hFE, "R10 B");
    rd_dir(8'hFC, "R10 X");
    rd_dir(8'hFD, "R10 SP");

    // R1 R2 R3 R4: direct sweep write then read
    for (int a = 0; a < 256; a++) wr_dir(8'(a), 8'(a) ^ 8'h5A);
    for (int a = 0; a < 256; a++) begin
      if (a < 48)       rd_dir(8'(a), "R1 ram");
      else if (a < 128) rd_dir(8'(a), "R2 ones");
      else if (a >= 252 && a <= 254) rd_dir(8'(a), "R4 ptr loc");
      else              rd_dir(8'(a), "R3 hole");
    end

    // R5: plain indirect through B and X, pointer unchanged
    wr_dir(8'hFE, 8'h10);
    wr_dir(8'hFC, 8'h2A);
    access(1'b1, 2'd1, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, "R5 ind B");
    access(1'b1, 2'd1, 1'b1, 8'h00, 1'b1, 8'hC3, 1'b0, 4'h0, 1'b1, "R5 ind X wr");
    rd_dir(8'hFE, "R5 B kept");
    rd_dir(8'hFC, "R5 X kept");
    rd_dir(8'h2A, "R5 X write landed");

    // R6: post-increment across the RAM/ones boundary and wrap
    wr_dir(8'hFE, 8'h2E);
    for (int i = 0; i < 4; i++)
      access(1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, "R6 inc B read");
    rd_dir(8'hFE, "R6 B after incs");
    wr_dir(8'hFC, 8'hFF);
    access(1'b1, 2'd2, 1'b1, 8'h00, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, "R6 inc X at FF");
    rd_dir(8'hFC, "R6 X wrap to 00");

    // R7: post-decrement with wrap
    access(1'b1, 2'd3, 1'b1, 8'h00, 1'b1, 8'h77, 1'b0, 4'h0, 1'b1, "R7 dec X at 00");
    rd_dir(8'hFC, "R7 X wrap to FF");
    rd_dir(8'h00, "R7 write via old X");
    wr_dir(8'hFE, 8'h05);
    for (int i = 0; i < 3; i++)
      access(1'b1, 2'd3, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 4'h0, 1'b1, "R7 dec B read");
    rd_dir(8'hFE, "R7 B after decs");

    // R8: short immediate and its priority
    access(1'b0, 2'd0, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'hF, 1'b0, "");
    rd_dir(8'hFE, "R8 ldb 0F");
    access(1'b1, 2'd2, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 4'h3, 1'b1, "R8 ldb vs inc");
    rd_dir(8'hFE, "R8 ldb beats inc");
    access(1'b1, 2'd0, 1'b0, 8'hFE, 1'b1, 8'hAA, 1'b1, 4'h9, 1'b0, "");
    rd_dir(8'hFE, "R8 ldb beats write");

    // R9: stepping pointer addresses its own location
    wr_dir(8'hFE, 8'hFE);
    access(1'b1, 2'd2, 1'b0, 8'h00, 1'b1, 8'h33, 1'b0, 4'h0, 1'b1, "R9 B at FE");
    rd_dir(8'hFE, "R9 step beats write B");
    wr_dir(8'hFC, 8'hFC);
    access(1'b1, 2'd3, 1'b1, 8'h00, 1'b1, 8'h44, 1'b0, 4'h0, 1'b1, "R9 X at FC");
    rd_dir(8'hFC, "R9 step beats write X");

    // R11: idle cycles with write enable and step mode do nothing
    wr_dir(8'hFE, 8'h08);
    access(1'b0, 2'd0, 1'b0, 8'h05, 1'b1, 8'hEE, 1'b0, 4'h0, 1'b0, "");
    access(1'b0, 2'd2, 1'b0, 8'h00, 1'b1, 8'hEE, 1'b0, 4'h0, 1'b0, "");
    rd_dir(8'h05, "R11 ram kept");
    rd_dir(8'h08, "R11 ram at B kept");
    rd_dir(8'hFE, "R11 B kept");

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule